// File: doc/BRIEF.md
# Slow-rate infrared pulse modem

This block is the bit-level layer of a slow-rate infrared link. On the transmit side it takes bytes from a valid/ready stream and sends each one as an asynchronous frame. Every zero bit in that frame is a short light pulse at the start of the bit, and every one bit leaves the LED dark. On the receive side it watches the photodiode input for pulse edges and rebuilds bytes from them. Recovered bytes leave on a second valid/ready stream. A byte whose stop position carries a pulse is reported on a one-cycle framing-error strobe. Byte stuffing and frame wrapping happen upstream.

Timing comes from a sub-tick prescaler. Its division ratio is chosen by a 2-bit clock selection, one ratio for each of four supported input clock rates. `SUBS` sub-ticks make one base period at the fastest rate. A 6-bit rate divisor stretches each bit to `(div+1)*SUBS` sub-ticks. A 5-bit width field sets the pulse length in sub-ticks. Plain status outputs report whether the current rate and clock settings are usable.

Back-pressure rules:
- Transmit: `tx_ready` is high only while the modem is enabled, the configuration is valid and no frame is in progress. A byte moves when `tx_valid` and `tx_ready` are both high on a clock edge.
- Receive: `rx_valid` stays high with `rx_data` frozen until `rx_ready` is seen high. The receiver never stalls the line, so a byte that completes while an earlier one is still unclaimed is discarded.

Top module: `sir_phy`

## Requirements
- R1: `cfg_ok` is 1 and `cfg_err` is 0 exactly when `baud_div` is one of 0, 1, 2, 5 or 11 and bit `clk_sel` of parameter `CLK_MASK` is set. Otherwise `cfg_ok` is 0, `cfg_err` is 1, and nothing is accepted or sent.
- R2: A sub-tick lasts `PRE_SEL<clk_sel>` clocks. A bit lasts `(baud_div+1)*SUBS` sub-ticks, so successive bit starts are exactly that many clocks apart.
- R3: A frame is frame position 0 carrying a zero start bit, positions 1 to 8 carrying the data least significant bit first, and position 9 carrying a one stop bit. A pulse is emitted only for zero bits, beginning at the start of that bit; the stop bit never pulses.
- R4: Each pulse lasts `min(max(pulse_width,1), (baud_div+1)*SUBS/2)` sub-ticks, so a width of 0 acts as 1 and no pulse exceeds half a bit.
- R5: `led_tx` equals the internal pulse XOR `tx_led_inv`, so it idles at `tx_led_inv`. The receiver treats `led_rx` XOR `rx_led_inv` as the active-high pulse.
- R6: While `phy_en` is 0, `tx_ready` is 0, `led_tx` stays at its idle level, and pulses on `led_rx` produce neither a byte nor a framing error.
- R7: `tx_ready` falls in the cycle after an accepted byte and rises again after the stop bit ends. The divisor and width in force at acceptance govern the whole frame.
- R8: On receive, a rising pulse edge begins a frame. After that, a bit window containing a pulse edge decodes as 0 and an empty window decodes as 1. The eight data bits are delivered least significant bit first on `rx_data` with `rx_valid`.
- R9: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` hold. A byte completing in that state is dropped.
- R10: A pulse in the stop-bit window raises `rx_frame_err` for one cycle, and that byte is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_en | input | 1 | Modem enable |
| clk_sel | input | 2 | Input clock rate selection (picks prescaler ratio) |
| baud_div | input | 6 | Bit-rate divisor |
| pulse_width | input | 5 | Pulse length in sub-ticks |
| tx_led_inv | input | 1 | Invert transmit LED drive |
| rx_led_inv | input | 1 | Invert receive LED input |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Recovered byte |
| rx_valid | output | 1 | Recovered byte valid |
| rx_ready | input | 1 | Consumer takes recovered byte |
| led_tx | output | 1 | LED drive |
| led_rx | input | 1 | Photodiode input |
| rx_frame_err | output | 1 | One-cycle strobe for missing stop bit |
| cfg_ok | output | 1 | Configuration usable |
| cfg_err | output | 1 | Configuration unsupported |

## Verification
Every supported divisor is swept over three clock selections. Bytes of mixed bit content are sent with the transmit output looped back to the receiver. Pulse spacings tell a wrong bit length from a wrong bit order. Pulse widths, probed with widths of 0, 1, 3, 12 and 31, separate the floor from the half-bit cap.

Hand-made receive waveforms are used as well:
- a clean frame, which checks decoding on its own;
- a frame with a pulse in the stop position, which checks the framing error;
- pulses sent while disabled, which must produce nothing.

An unclaimed byte followed by a second byte shows the drop rule. Changing the divisor right after a handshake shows that the frame keeps the setting it was accepted with.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int DIV_W    = 6;
  localparam int PW_W     = 5;
  localparam int BYTE_W   = 8;
  localparam int FRAME_LEN = BYTE_W + 2;

  typedef enum logic [1:0] {TX_IDLE, TX_ALIGN, TX_SEND} tx_state_t;

  function automatic logic rate_supported(input logic [DIV_W-1:0] d);
    return (d == 6'd0) || (d == 6'd1) || (d == 6'd2) || (d == 6'd5) || (d == 6'd11);
  endfunction
endpackage

// File: rtl/sir_tick_gen.sv
module sir_tick_gen #(
  parameter int PRE_SEL0 = 22,
  parameter int PRE_SEL1 = 26,
  parameter int PRE_SEL2 = 30,
  parameter int PRE_SEL3 = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] clk_sel,
  output logic       sub_tick
);
  localparam int PM01 = (PRE_SEL0 > PRE_SEL1) ? PRE_SEL0 : PRE_SEL1;
  localparam int PM23 = (PRE_SEL2 > PRE_SEL3) ? PRE_SEL2 : PRE_SEL3;
  localparam int PMAX = (PM01 > PM23) ? PM01 : PM23;
  localparam int CW   = $clog2(PMAX + 1);

  logic [CW-1:0] cnt, lim;

  always_comb begin
    case (clk_sel)
      2'd0:    lim = CW'(PRE_SEL0 - 1);
      2'd1:    lim = CW'(PRE_SEL1 - 1);
      2'd2:    lim = CW'(PRE_SEL2 - 1);
      default: lim = CW'(PRE_SEL3 - 1);
    endcase
  end

  assign sub_tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || sub_tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R2: the prescaler never runs past its limit while enabled
  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(clk_sel) && !sub_tick) |=> (cnt != '0) || !run);
endmodule

// File: rtl/sir_tx.sv
module sir_tx
  import sir_pkg::*;
#(
  parameter int SUBS = 16,
  parameter int LW   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sub_tick,
  input  logic [DIV_W-1:0]  div,
  input  logic [PW_W-1:0]   pw,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              pulse
);
  tx_state_t            st;
  logic [FRAME_LEN-1:0] sh;
  logic [3:0]           bi;
  logic [LW-1:0]        sc, len, wid;
  logic [LW-1:0]        len_n, half_n, wid_n;

  always_comb begin
    len_n  = LW'((int'(div) + 1) * SUBS);
    half_n = len_n >> 1;
    wid_n  = (pw == '0) ? LW'(1) : LW'(pw);
    if (wid_n > half_n) wid_n = half_n;
  end

  assign tx_ready = run && (st == TX_IDLE);
  assign pulse    = (st == TX_SEND) && !sh[0] && (sc < wid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; sh <= '1; bi <= '0; sc <= '0; len <= '0; wid <= '0;
    end else if (!run) begin
      st <= TX_IDLE; bi <= '0; sc <= '0;
    end else begin
      case (st)
        TX_IDLE: if (tx_valid) begin
          sh  <= {1'b1, tx_data, 1'b0};
          len <= len_n;
          wid <= wid_n;
          st  <= TX_ALIGN;
        end
        TX_ALIGN: if (sub_tick) begin
          st <= TX_SEND; sc <= '0; bi <= '0;
        end
        TX_SEND: if (sub_tick) begin
          if (sc == len - 1'b1) begin
            sc <= '0;
            sh <= {1'b1, sh[FRAME_LEN-1:1]};
            if (bi == 4'(FRAME_LEN - 1)) st <= TX_IDLE;
            else                         bi <= bi + 1'b1;
          end else begin
            sc <= sc + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_stop_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_SEND && bi == 4'(FRAME_LEN - 1)) |-> !pulse);
endmodule

// File: rtl/sir_rx.sv
module sir_rx
  import sir_pkg::*;
#(
  parameter int SUBS        = 16,
  parameter int LW          = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sub_tick,
  input  logic              rx_pin,
  input  logic              rx_inv,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  logic [SYNC_STAGES-1:0] sy;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sy[0] <= 1'b0;
          else        sy[0] <= rx_pin ^ rx_inv;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sy[g] <= 1'b0;
          else        sy[g] <= sy[g-1];
        end
      end
    end
  endgenerate

  logic          lvl_q, busy, seen, edge_now, bit_now;
  logic [LW:0]   cnt, len_n, start_n;
  logic [3:0]    nb;
  logic [BYTE_W-1:0] sh;

  assign len_n    = (LW+1)'((int'(div) + 1) * SUBS);
  assign start_n  = len_n + (len_n >> 1);
  assign edge_now = run && sy[SYNC_STAGES-1] && !lvl_q;
  assign bit_now  = !(seen || edge_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0; busy <= 1'b0; seen <= 1'b0; cnt <= '0; nb <= '0;
      sh <= '0; rx_data <= '0; rx_valid <= 1'b0; rx_frame_err <= 1'b0;
    end else begin
      lvl_q        <= sy[SYNC_STAGES-1];
      rx_frame_err <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!run) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (edge_now) begin
          busy <= 1'b1; cnt <= start_n; nb <= '0; seen <= 1'b0;
        end
      end else begin
        if (edge_now) seen <= 1'b1;
        if (sub_tick) begin
          if (cnt == (LW+1)'(1)) begin
            seen <= 1'b0;
            cnt  <= len_n;
            if (nb == 4'(BYTE_W)) begin
              busy <= 1'b0;
              if (!bit_now) begin
                rx_frame_err <= 1'b1;
              end else if (!(rx_valid && !rx_ready)) begin
                rx_data  <= sh;
                rx_valid <= 1'b1;
              end
            end else begin
              sh <= {bit_now, sh[BYTE_W-1:1]};
              nb <= nb + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_err_no_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> !$rose(rx_valid));
endmodule

// File: rtl/sir_phy.sv
module sir_phy
  import sir_pkg::*;
#(
  parameter int         SUBS        = 16,
  parameter int         PRE_SEL0    = 22,
  parameter int         PRE_SEL1    = 26,
  parameter int         PRE_SEL2    = 30,
  parameter int         PRE_SEL3    = 35,
  parameter logic [3:0] CLK_MASK    = 4'b1111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_en,
  input  logic [1:0] clk_sel,
  input  logic [5:0] baud_div,
  input  logic [4:0] pulse_width,
  input  logic       tx_led_inv,
  input  logic       rx_led_inv,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       led_tx,
  input  logic       led_rx,
  output logic       rx_frame_err,
  output logic       cfg_ok,
  output logic       cfg_err
);
  localparam int LW = $clog2((1 << DIV_W) * SUBS + 1);

  logic run, sub_tick, tx_pulse;

  assign cfg_ok  = rate_supported(baud_div) && CLK_MASK[clk_sel];
  assign cfg_err = !cfg_ok;
  assign run     = phy_en && cfg_ok;
  assign led_tx  = tx_pulse ^ tx_led_inv;

  sir_tick_gen #(
    .PRE_SEL0(PRE_SEL0), .PRE_SEL1(PRE_SEL1),
    .PRE_SEL2(PRE_SEL2), .PRE_SEL3(PRE_SEL3)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .sub_tick(sub_tick)
  );

  sir_tx #(.SUBS(SUBS), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .sub_tick(sub_tick),
    .div(baud_div), .pw(pulse_width), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .pulse(tx_pulse)
  );

  sir_rx #(.SUBS(SUBS), .LW(LW), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(run), .sub_tick(sub_tick),
    .rx_pin(led_rx), .rx_inv(rx_led_inv), .div(baud_div),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err)
  );

  assert_off_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tx_pulse);

  assert_bad_cfg_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tx_ready);
endmodule

// File: tb/sim_sir_phy.sv
module sim_sir_phy;
  localparam int CLK_PERIOD = 10;
  localparam int SUBS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic phy_en = 0, tx_led_inv = 0, rx_led_inv = 0, tx_valid = 0, rx_ready = 1;
  logic [1:0] clk_sel = 0;
  logic [5:0] baud_div = 0;
  logic [4:0] pulse_width = 12;
  logic [7:0] tx_data = 0;
  logic tx_ready, rx_valid, led_tx, rx_frame_err, cfg_ok, cfg_err;
  logic [7:0] rx_data;
  logic manual = 0, man_pin = 0;
  wire led_rx = manual ? man_pin : (led_tx ^ tx_led_inv ^ rx_led_inv);

  sir_phy #(.SUBS(SUBS), .PRE_SEL0(2), .PRE_SEL1(3), .PRE_SEL2(4), .PRE_SEL3(5),
            .CLK_MASK(4'b0111)) u0 (
    .clk(clk), .rst_n(rst_n), .phy_en(phy_en), .clk_sel(clk_sel),
    .baud_div(baud_div), .pulse_width(pulse_width), .tx_led_inv(tx_led_inv),
    .rx_led_inv(rx_led_inv), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .led_tx(led_tx), .led_rx(led_rx),
    .rx_frame_err(rx_frame_err), .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int np = 0, got_cnt = 0, err_cnt = 0;
  int rise_t [16];
  int wid [16];
  logic [7:0] got_data = 0;
  logic lvl_q = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic lvl;
    lvl = led_tx ^ tx_led_inv;
    if (lvl && !lvl_q) begin
      if (np < 16) rise_t[np] = cyc;
      np = np + 1;
    end
    if (!lvl && lvl_q && np > 0 && np <= 16) wid[np-1] = cyc - rise_t[np-1];
    lvl_q = lvl;
    if (rx_valid && rx_ready) begin got_cnt = got_cnt + 1; got_data = rx_data; end
    if (rx_frame_err) err_cnt = err_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Sends one byte; optionally alters divisor and width right after the handshake.
  task automatic send(input logic [7:0] d, input bit alter);
    logic r;
    logic [5:0] keep_div;
    logic [4:0] keep_pw;
    keep_div = baud_div; keep_pw = pulse_width;
    tx_data = d; tx_valid = 1;
    forever begin
      r = tx_ready;
      tick(1);
      if (r) break;
    end
    tx_valid = 0;
    if (alter) begin baud_div = 0; pulse_width = 1; end
    while (!tx_ready) tick(1);
    baud_div = keep_div; pulse_width = keep_pw;
  endtask

  // Checks recorded pulses against the expected frame waveform.
  task automatic check_wave(input logic [7:0] d, input int lc, input int wc, input string tag);
    int kz [10];
    int nz = 0;
    bit pos_ok = 1, w_ok = 1;
    for (int k = 0; k < 10; k++) begin
      logic b;
      b = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
      if (!b) begin kz[nz] = k; nz++; end
    end
    chk(np == nz, {tag, " R3 pulse count"}, np, nz);
    if (np == nz) begin
      for (int i = 0; i < nz; i++) begin
        if (rise_t[i] - rise_t[0] != kz[i] * lc) pos_ok = 0;
        if (wid[i] != wc) w_ok = 0;
      end
      chk(pos_ok, {tag, " R2 R3 pulse spacing"}, rise_t[nz-1] - rise_t[0], kz[nz-1] * lc);
      chk(w_ok, {tag, " R4 pulse width"}, wid[0], wc);
    end
  endtask

  task automatic drive_frame(input logic [9:0] bits, input int lc, input int wc);
    for (int k = 0; k < 10; k++) begin
      if (!bits[k]) begin
        man_pin = 1'b1 ^ rx_led_inv; tick(wc);
        man_pin = 1'b0 ^ rx_led_inv; tick(lc - wc);
      end else begin
        man_pin = rx_led_inv; tick(lc);
      end
    end
    tick(2 * lc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int divs [5] = '{0, 1, 2, 5, 11};
    int pws [5] = '{0, 1, 3, 12, 31};
    int g0, e0;
    tick(5);
    rst_n = 1;
    tick(2);
    // reset state
    chk(tx_ready == 0 && rx_valid == 0 && rx_frame_err == 0 && led_tx == 0,
        "R6 reset state", {tx_ready, rx_valid, rx_frame_err, led_tx}, 0);

    // R1: divisor sweep with clock selection 0
    for (int d = 0; d < 64; d++) begin
      bit exp_ok;
      baud_div = 6'(d);
      exp_ok = (d == 0) || (d == 1) || (d == 2) || (d == 5) || (d == 11);
      tick(1);
      chk(cfg_ok == exp_ok && cfg_err == !exp_ok, "R1 divisor support", cfg_ok, exp_ok);
    end
    baud_div = 11; clk_sel = 3; phy_en = 1; tx_valid = 1;
    tick(3);
    chk(cfg_err == 1 && tx_ready == 0, "R1 unsupported clock selection", cfg_err, 1);
    baud_div = 3; clk_sel = 0;
    tick(3);
    chk(cfg_err == 1 && tx_ready == 0 && np == 0, "R1 unsupported divisor idle", tx_ready, 0);
    tx_valid = 0; baud_div = 0;
    tick(3);

    // main sweep: R2 R3 R4 R5 R8 through loopback
    for (int s = 0; s < 3; s++) begin
      for (int di = 0; di < 5; di++) begin
        int pre, lc, w, wc;
        clk_sel = 2'(s); baud_div = 6'(divs[di]);
        pulse_width = 5'(pws[(s + di) % 5]);
        tx_led_inv = di[0]; rx_led_inv = s[0];
        pre = s + 2;
        lc = (divs[di] + 1) * SUBS * pre;
        w = (pws[(s + di) % 5] == 0) ? 1 : pws[(s + di) % 5];
        if (w > (divs[di] + 1) * SUBS / 2) w = (divs[di] + 1) * SUBS / 2;
        wc = w * pre;
        tick(4);
        chk(led_tx == tx_led_inv, "R5 idle LED level", led_tx, tx_led_inv);
        for (int b = 0; b < 2; b++) begin
          logic [7:0] d;
          d = 8'hA5 ^ 8'(s * 16 + di * 7);
          if (b == 1) d = ~d ^ 8'h30;
          np = 0; g0 = got_cnt;
          send(d, 0);
          tick(lc);
          check_wave(d, lc, wc, "sweep");
          chk(got_cnt == g0 + 1 && got_data == d, "R8 R5 loopback byte", got_data, d);
        end
      end
    end

    // R7: settings latched at acceptance
    tx_led_inv = 0; rx_led_inv = 0; clk_sel = 0; baud_div = 1; pulse_width = 31;
    tick(4);
    np = 0;
    send(8'h5A, 1);
    check_wave(8'h5A, 2 * SUBS * 2, 4 * 2, "R7 latched config");
    tick(100);

    // R9: unclaimed byte holds, next byte dropped
    clk_sel = 1; baud_div = 2; pulse_width = 12;
    tick(4);
    rx_ready = 0; g0 = got_cnt;
    send(8'h3C, 0);
    send(8'hC3, 0);
    tick(40 * 3 * 3);
    chk(rx_valid == 1 && rx_data == 8'h3C, "R9 held byte", rx_data, 8'h3C);
    rx_ready = 1;
    tick(3);
    chk(got_cnt == g0 + 1 && got_data == 8'h3C && rx_valid == 0, "R9 second byte dropped",
        got_cnt - g0, 1);

    // R8 R10: hand-made receive waveforms (divisor 2, selection 1: 36 clocks per bit)
    manual = 1; man_pin = 0;
    tick(20);
    g0 = got_cnt; e0 = err_cnt;
    drive_frame({1'b1, 8'h96, 1'b0}, 36, 6);
    chk(got_cnt == g0 + 1 && got_data == 8'h96 && err_cnt == e0, "R8 manual frame", got_data, 8'h96);
    g0 = got_cnt; e0 = err_cnt;
    drive_frame({1'b0, 8'h71, 1'b0}, 36, 6);
    chk(err_cnt == e0 + 1 && got_cnt == g0, "R10 missing stop bit", err_cnt - e0, 1);
    rx_led_inv = 1; man_pin = 1;
    tick(20);
    g0 = got_cnt;
    drive_frame({1'b1, 8'h0F, 1'b0}, 36, 6);
    chk(got_cnt == g0 + 1 && got_data == 8'h0F, "R5 inverted receive input", got_data, 8'h0F);

    // R6: disabled modem ignores everything
    phy_en = 0; tx_valid = 1; np = 0; g0 = got_cnt; e0 = err_cnt;
    begin
      bit ok = 1;
      for (int i = 0; i < 50; i++) begin
        tick(1);
        if (tx_ready || led_tx != tx_led_inv) ok = 0;
      end
      chk(ok, "R6 transmitter idle while disabled", tx_ready, 0);
    end
    tx_valid = 0;
    drive_frame({1'b1, 8'h00, 1'b0}, 36, 6);
    drive_frame({1'b0, 8'h55, 1'b0}, 36, 6);
    phy_en = 1;
    tick(200);
    chk(got_cnt == g0 && err_cnt == e0 && np == 0, "R6 receive ignored while disabled",
        got_cnt - g0 + err_cnt - e0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule